// File: doc/BRIEF.md
# Bidirectional Port with Per-Pin Pulse-Width Takeover

An eight-pin general-purpose I/O port controlled over a small synchronous register bus. Software sets each pin as input or output through a direction register. It drives output pins from a data latch and reads the port through a single data address. For that data address, each bit returns the latch bit when the pin is an output and the synchronised pin level when the pin is an input.

A third register lets any pin be given to an external pulse-width generator. While that takeover bit is set, the pin is always driven and carries the generator's signal, whatever its direction bit says. Pin levels pass through a multi-flop synchroniser before they reach read data. The pin drive value and output enable leave the block from flops.

Top module: `gpio_pwm_port`

## Requirements
- R1: After synchronous reset, the direction, latch and takeover registers are all zero, every `pin_oe` bit is 0 and every `pin_out` bit is 0.
- R2: The direction register at address 0x05 stores all eight written bits and reads them back unchanged. Bit i = 1 selects output and bit i = 0 selects input for pin i.
- R3: The takeover register at address 0x28 stores all eight written bits and reads them back. Bit i = 1 gives pin i to `pwm_in[i]`.
- R4: A read of address 0x01 returns, for each bit i, the latch bit when direction bit i is 1 and the synchronised `pin_in[i]` when direction bit i is 0.
- R5: A write to address 0x01 updates every latch bit whatever the direction bits are. Latch bits of input pins do not appear in read data until that pin is made an output.
- R6: With takeover bit i clear, `pin_oe[i]` equals direction bit i. `pin_out[i]` equals latch bit i when the pin is an output and is 0 when the pin is an input.
- R7: With takeover bit i set, `pin_oe[i]` is 1 and `pin_out[i]` follows `pwm_in[i]`, whatever direction bit i is.
- R8: `pin_out` and `pin_oe` are registered. They reflect register state and `pwm_in` one rising clock edge after those change.
- R9: A change on `pin_in` appears in data-register read data after exactly two rising clock edges.
- R10: Reads from any address other than 0x01, 0x05 and 0x28 return 0x00. Writes to such addresses change no register.
- R11: A register changes only on a rising edge where `bus_we` is 1. With `bus_we` at 0, address and write data have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| pin_in | input | 8 | Levels sampled from the pads |
| pwm_in | input | 8 | Pulse-width signals, one per pin |
| pin_out | output | 8 | Registered pad drive value |
| pin_oe | output | 8 | Registered pad output enable |

## Verification
The bench builds the block with its default parameters: eight pins, an eight-bit address and a two-flop synchroniser. At that size the direction and takeover registers can each be swept through all 256 values. The data read path and the pad drive are checked over a grid of direction, latch, pin and takeover patterns, with expected words computed by bitwise arithmetic. The short synchroniser depth makes it possible to observe the edge on which a pin change first reaches read data. The eight-bit address space is probed at several unmapped points for both reads and writes.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_PWM  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= async_in;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= '0;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign sync_out = chain_q[LAST];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int              WIDTH     = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h05,
  parameter logic [ADDR_W-1:0] PWM_ADDR  = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pins_sync,
  output logic [WIDTH-1:0]  rdata,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  pwm_q
);

  reg_sel_e sel;

  always_comb begin
    if (addr == DATA_ADDR)     sel = SEL_DATA;
    else if (addr == DIR_ADDR) sel = SEL_DIR;
    else if (addr == PWM_ADDR) sel = SEL_PWM;
    else                       sel = SEL_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
      lat_q <= '0;
      pwm_q <= '0;
    end else if (we) begin
      case (sel)
        SEL_DATA: lat_q <= wdata;
        SEL_DIR:  dir_q <= wdata;
        SEL_PWM:  pwm_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA: rdata = (dir_q & lat_q) | (~dir_q & pins_sync);
      SEL_DIR:  rdata = dir_q;
      SEL_PWM:  rdata = pwm_q;
      default:  rdata = '0;
    endcase
  end

  // R11: registers hold whenever the strobe is low
  assert_hold_without_write_R11: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(dir_q) && $stable(lat_q) && $stable(pwm_q)));

  // R10: writes outside the map leave every register alone
  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_NONE) |=> ($stable(dir_q) && $stable(lat_q) && $stable(pwm_q)));

  // R3: a takeover write lands on the next edge
  assert_pwm_write_R3: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_PWM) |=> (pwm_q == $past(wdata)));

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] pwm_q,
  input  logic [WIDTH-1:0] pwm_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic drive_nxt;
      logic oe_nxt;

      always_comb begin
        if (pwm_q[i]) begin
          oe_nxt    = 1'b1;
          drive_nxt = pwm_in[i];
        end else begin
          oe_nxt    = dir_q[i];
          drive_nxt = dir_q[i] & lat_q[i];
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          pin_oe[i]  <= 1'b0;
          pin_out[i] <= 1'b0;
        end else begin
          pin_oe[i]  <= oe_nxt;
          pin_out[i] <= drive_nxt;
        end
      end

      // R7: takeover forces the pin on and passes the generator through
      assert_pwm_owns_pin_R7: assert property (@(posedge clk) disable iff (rst)
        pwm_q[i] |=> (pin_oe[i] && pin_out[i] == $past(pwm_in[i])));

      // R6: an input pin without takeover is released and driven low
      assert_input_released_R6: assert property (@(posedge clk) disable iff (rst)
        (!pwm_q[i] && !dir_q[i]) |=> (!pin_oe[i] && !pin_out[i]));
    end
  endgenerate

endmodule

// File: rtl/gpio_pwm_port.sv
module gpio_pwm_port #(
  parameter int                WIDTH       = 8,
  parameter int                ADDR_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR   = 8'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR    = 8'h05,
  parameter logic [ADDR_W-1:0] PWM_ADDR    = 8'h28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  pwm_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] pwm_q;

  gpio_pin_sync #(
    .WIDTH  (WIDTH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  gpio_port_regs #(
    .WIDTH     (WIDTH),
    .ADDR_W    (ADDR_W),
    .DATA_ADDR (DATA_ADDR),
    .DIR_ADDR  (DIR_ADDR),
    .PWM_ADDR  (PWM_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .pins_sync (pins_sync),
    .rdata     (bus_rdata),
    .dir_q     (dir_q),
    .lat_q     (lat_q),
    .pwm_q     (pwm_q)
  );

  gpio_pin_drive #(
    .WIDTH (WIDTH)
  ) u_drive (
    .clk     (clk),
    .rst     (rst),
    .dir_q   (dir_q),
    .lat_q   (lat_q),
    .pwm_q   (pwm_q),
    .pwm_in  (pwm_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

endmodule

// File: tb/gpio_pwm_port_test.sv
module gpio_pwm_port_test;

  localparam logic [7:0] A_DATA = 8'h01;
  localparam logic [7:0] A_DIR  = 8'h05;
  localparam logic [7:0] A_PWM  = 8'h28;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pwm_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_pwm_port uut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pwm_in    (pwm_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // starts and ends at a falling edge, spans one rising edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] dirs [5];
    logic [7:0] lats [4];
    logic [7:0] pins [3];
    logic [7:0] pwms [4];
    dirs = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h0F};
    lats = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
    pins = '{8'h00, 8'hFF, 8'h69};
    pwms = '{8'h00, 8'hFF, 8'h81, 8'h36};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(A_DIR, v);  check("R1 dir reset", v, 8'h00);
    rd(A_PWM, v);  check("R1 pwm reset", v, 8'h00);
    rd(A_DATA, v); check("R1 data reset", v, 8'h00);
    check("R1 oe reset", pin_oe, 8'h00);
    check("R1 out reset", pin_out, 8'h00);
    @(negedge clk);

    // R2 and R3: full sweeps
    for (int k = 0; k < 256; k++) begin
      wr(A_DIR, 8'(k));
      rd(A_DIR, v); check("R2 dir readback", v, 8'(k));
      @(negedge clk);
    end
    for (int k = 0; k < 256; k++) begin
      wr(A_PWM, 8'(k));
      rd(A_PWM, v); check("R3 pwm readback", v, 8'(k));
      @(negedge clk);
    end
    wr(A_PWM, 8'h00);

    // R4: data read mixes latch and pin per direction
    foreach (dirs[a]) foreach (lats[b]) foreach (pins[c]) begin
      wr(A_DIR, dirs[a]);
      wr(A_DATA, lats[b]);
      pin_in = pins[c];
      repeat (3) @(negedge clk);
      rd(A_DATA, v);
      check("R4 data read", v, (dirs[a] & lats[b]) | (~dirs[a] & pins[c]));
      @(negedge clk);
    end

    // R5: latch written while inputs, hidden until output
    pin_in = 8'h0F;
    wr(A_DIR, 8'h00);
    wr(A_DATA, 8'hB6);
    repeat (3) @(negedge clk);
    rd(A_DATA, v); check("R5 input hides latch", v, 8'h0F);
    @(negedge clk);
    wr(A_DIR, 8'hFF);
    rd(A_DATA, v); check("R5 latch kept", v, 8'hB6);
    @(negedge clk);

    // R6, R7: pad drive over direction/latch/takeover/generator grid
    foreach (dirs[a]) foreach (lats[b]) foreach (pwms[c]) begin
      wr(A_DIR, dirs[a]);
      wr(A_DATA, lats[b]);
      wr(A_PWM, pwms[c]);
      pwm_in = lats[b] ^ 8'h99;
      repeat (2) @(negedge clk);
      check("R6 R7 oe", pin_oe, pwms[c] | dirs[a]);
      check("R6 R7 out", pin_out,
            (pwms[c] & (lats[b] ^ 8'h99)) | (~pwms[c] & dirs[a] & lats[b]));
    end

    // R8: one edge of latency on the drive outputs
    wr(A_DIR, 8'hF0);
    wr(A_DATA, 8'hA0);
    wr(A_PWM, 8'h0F);
    pwm_in = 8'h00;
    repeat (2) @(negedge clk);
    check("R8 settled", pin_out, 8'hA0);
    pwm_in = 8'h05;
    #1; check("R8 before edge", pin_out, 8'hA0);
    @(negedge clk);
    check("R8 after edge", pin_out, 8'hA5);
    wr(A_PWM, 8'h00);
    check("R8 oe before edge", pin_oe, 8'hFF);
    @(negedge clk);
    check("R8 oe after edge", pin_oe, 8'hF0);

    // R9: two-edge synchroniser latency
    wr(A_DIR, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hE7;
    rd(A_DATA, v); check("R9 zero edges", v, 8'h00);
    @(negedge clk);
    rd(A_DATA, v); check("R9 one edge", v, 8'h00);
    @(negedge clk);
    rd(A_DATA, v); check("R9 two edges", v, 8'hE7);

    // R10: unmapped reads and writes
    wr(A_DIR, 8'h5C);
    wr(A_DATA, 8'h33);
    wr(A_PWM, 8'h81);
    foreach (pwms[c]) begin
      logic [7:0] a;
      a = (c == 0) ? 8'h00 : (c == 1) ? 8'h02 : (c == 2) ? 8'h29 : 8'hFF;
      rd(a, v); check("R10 unmapped read", v, 8'h00);
      wr(a, 8'hFF);
    end
    rd(A_DIR, v); check("R10 dir untouched", v, 8'h5C);
    rd(A_PWM, v); check("R10 pwm untouched", v, 8'h81);
    wr(A_DIR, 8'hFF);
    rd(A_DATA, v); check("R10 latch untouched", v, 8'h33);
    @(negedge clk);

    // R11: strobe low means no write
    bus_we = 1'b0;
    bus_wdata = 8'h77;
    bus_addr = A_DIR;  @(negedge clk);
    bus_addr = A_DATA; @(negedge clk);
    bus_addr = A_PWM;  @(negedge clk);
    rd(A_DIR, v);  check("R11 dir held", v, 8'hFF);
    rd(A_DATA, v); check("R11 latch held", v, 8'h33);
    rd(A_PWM, v);  check("R11 pwm held", v, 8'h81);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule